// File: doc/BRIEF.md
# Ethernet Transmit Gap Guard and Frame Length Limiter

This block sits beside a MAC datapath. It keeps the transmitter quiet for a programmed inter-packet gap after each frame it sends. It also watches both the transmit and the receive byte streams for frames that run past a configured length limit. The gap is measured in nibble times, which the surrounding logic marks with a one-cycle tick enable. The gap length is a 7-bit setting plus a constant that depends on the duplex mode. The offset is 3 nibble times in full duplex and 6 in half duplex, so the recommended settings 0x15 (full) and 0x12 (half) both give the minimum standard gap of 24 nibble times. At 100 Mb/s that is 0.96 µs, and at 10 Mb/s it is 9.6 µs.

The gap timer has two states. `GAP_OPEN` is entered at reset and holds `tx_permit` high. The transition *start* (`tx_done` in `GAP_OPEN`) loads the counter and moves to `GAP_HOLD`. In `GAP_HOLD`, *restart* (`tx_done` again) reloads the counter, *tick* decrements it, and *expire* (the tick that takes the counter to zero) returns to `GAP_OPEN`.

Each length checker has three states. `LEN_IDLE` is entered at reset, and no frame is open. `LEN_COUNT` counts bytes. `LEN_ABORTED` is entered after an abort and discards the rest of the frame. The transition *open* (a frame-start strobe, from any state) enters `LEN_COUNT` with a cleared count. The transition *overrun* (a byte past the limit while the huge-frame enable is 0) pulses the abort output and enters `LEN_ABORTED`.

Top module: `tx_gap_guard`

## Requirements
- R1: After reset, `tx_permit` is 1 and both `tx_abort` and `rx_abort` are 0.
- R2: The cycle after `tx_done` is high, `tx_permit` is 0. A `tx_done` that arrives while the gap is still running restarts the full gap from the settings present in that cycle.
- R3: With `full_duplex`=1 when the gap starts, `tx_permit` stays 0 for exactly `gap_set`+3 nibble ticks.
- R4: With `full_duplex`=0 when the gap starts, `tx_permit` stays 0 for exactly `gap_set`+6 nibble ticks.
- R5: The gap counter advances only on cycles where `nib_tick` is 1. A tick in the same cycle as `tx_done` is not counted.
- R6: `full_duplex` and `gap_set` are captured when the gap starts. Changes to them while the gap runs do not change its length.
- R7: `tx_permit` returns to 1 in the cycle after the last tick of the gap and stays 1 until the next `tx_done`, whatever ticks arrive.
- R8: On each path, a frame-start strobe clears the byte count, and a byte that is valid in the same cycle as the start strobe counts as byte 1. With `huge_en`=0, the valid byte number `max_len`+1 produces an abort pulse one cycle wide in the following cycle. A frame of exactly `max_len` bytes produces no abort.
- R9: After an abort, further bytes of the same frame produce no further pulse until the next frame-start strobe.
- R10: With `huge_en`=1, no frame length on either path produces an abort.
- R11: The transmit and receive checkers are independent. Bytes on one path never cause an abort on the other.
- R12: Valid bytes seen after reset and before any frame-start strobe are ignored and cause no abort, even with `max_len`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_tick | input | 1 | One cycle high per nibble time |
| tx_done | input | 1 | Pulse marking the end of a transmitted frame |
| full_duplex | input | 1 | 1 = full-duplex offset, 0 = half-duplex offset |
| gap_set | input | 7 | Programmed gap value |
| huge_en | input | 1 | 1 = no frame length limit |
| max_len | input | 16 | Largest permitted frame length in bytes |
| tx_byte_vld | input | 1 | Transmit byte valid |
| tx_sof | input | 1 | Transmit frame-start strobe |
| rx_byte_vld | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Receive frame-start strobe |
| tx_permit | output | 1 | High when a new frame may start |
| tx_abort | output | 1 | One-cycle pulse for an over-length transmit frame |
| rx_abort | output | 1 | One-cycle pulse for an over-length receive frame |

## Verification
The properties take the inputs as synchronous single-bit strobes. `tx_done` is a pulse that software and the MAC raise only at frame ends, and `max_len` and `huge_en` are treated as steady within a frame. The stimulus keeps to these assumptions: it changes the length settings only between frames, and it issues `tx_done` as single-cycle pulses. Ticks, byte-valid gaps and changes to the duplex and gap settings during a running gap are drawn at random from a fixed seed.

// File: rtl/ipg_guard_pkg.sv
package ipg_guard_pkg;
    typedef enum logic {
        GAP_OPEN,
        GAP_HOLD
    } gap_state_t;

    typedef enum logic [1:0] {
        LEN_IDLE,
        LEN_COUNT,
        LEN_ABORTED
    } len_state_t;
endpackage

// File: rtl/gap_timer.sv
module gap_timer
    import ipg_guard_pkg::*;
#(
    parameter int GAP_W  = 7,
    parameter int FD_OFS = 3,
    parameter int HD_OFS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_tick,
    input  logic             tx_done,
    input  logic             full_duplex,
    input  logic [GAP_W-1:0] gap_set,
    output logic             tx_permit
);
    localparam int CNT_W = GAP_W + 1;

    gap_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    // duplex offset applied at capture time only
    always_comb begin
        load_val = {1'b0, gap_set} + (full_duplex ? CNT_W'(FD_OFS) : CNT_W'(HD_OFS));
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GAP_OPEN: begin
                if (tx_done) begin
                    cnt_d   = load_val;
                    state_d = GAP_HOLD;
                end
            end
            GAP_HOLD: begin
                if (tx_done) begin
                    cnt_d = load_val;
                end else if (nib_tick) begin
                    if (cnt_q <= CNT_W'(1)) begin
                        cnt_d   = '0;
                        state_d = GAP_OPEN;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: state_d = GAP_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GAP_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tx_permit = (state_q == GAP_OPEN);
    end
endmodule

// File: rtl/frame_len_check.sv
module frame_len_check
    import ipg_guard_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             huge_en,
    input  logic [LEN_W-1:0] max_len,
    input  logic             byte_vld,
    input  logic             sof,
    output logic             abort
);
    len_state_t       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] base;
    logic             active;
    logic             abort_q, abort_d;

    always_comb begin
        base = sof ? '0 : cnt_q;
        unique case (state_q)
            LEN_IDLE:    active = sof;
            LEN_COUNT:   active = 1'b1;
            LEN_ABORTED: active = sof;
            default:     active = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        abort_d = 1'b0;
        if (sof) begin
            state_d = LEN_COUNT;
            cnt_d   = '0;
        end
        if (active && byte_vld) begin
            if (!huge_en && (base >= max_len)) begin
                abort_d = 1'b1;
                state_d = LEN_ABORTED;
            end else if (base != '1) begin
                cnt_d = base + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEN_IDLE;
            cnt_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            abort_q <= abort_d;
        end
    end

    always_comb begin
        abort = abort_q;
    end
endmodule

// File: rtl/tx_gap_guard.sv
module tx_gap_guard
    import ipg_guard_pkg::*;
#(
    parameter int GAP_W  = 7,
    parameter int LEN_W  = 16,
    parameter int FD_OFS = 3,
    parameter int HD_OFS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_tick,
    input  logic             tx_done,
    input  logic             full_duplex,
    input  logic [GAP_W-1:0] gap_set,
    input  logic             huge_en,
    input  logic [LEN_W-1:0] max_len,
    input  logic             tx_byte_vld,
    input  logic             tx_sof,
    input  logic             rx_byte_vld,
    input  logic             rx_sof,
    output logic             tx_permit,
    output logic             tx_abort,
    output logic             rx_abort
);
    localparam int N_PATHS = 2;

    logic [N_PATHS-1:0] vld_v, sof_v, abort_v;

    assign vld_v    = {rx_byte_vld, tx_byte_vld};
    assign sof_v    = {rx_sof, tx_sof};
    assign tx_abort = abort_v[0];
    assign rx_abort = abort_v[1];

    gap_timer #(
        .GAP_W (GAP_W),
        .FD_OFS(FD_OFS),
        .HD_OFS(HD_OFS)
    ) gap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_tick   (nib_tick),
        .tx_done    (tx_done),
        .full_duplex(full_duplex),
        .gap_set    (gap_set),
        .tx_permit  (tx_permit)
    );

    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
        frame_len_check #(
            .LEN_W(LEN_W)
        ) len_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .huge_en (huge_en),
            .max_len (max_len),
            .byte_vld(vld_v[p]),
            .sof     (sof_v[p]),
            .abort   (abort_v[p])
        );
    end
endmodule

// File: rtl/gap_guard_chk.sv
module gap_guard_chk #(
    parameter int GAP_W = 7,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nib_tick,
    input logic             tx_done,
    input logic             full_duplex,
    input logic [GAP_W-1:0] gap_set,
    input logic             huge_en,
    input logic [LEN_W-1:0] max_len,
    input logic             tx_byte_vld,
    input logic             tx_sof,
    input logic             rx_byte_vld,
    input logic             rx_sof,
    input logic             tx_permit,
    input logic             tx_abort,
    input logic             rx_abort
);
    // R2
    done_blocks_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_permit);

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_permit && !nib_tick && !tx_done) |=> !tx_permit);

    // R7
    permit_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_permit) |-> ($past(nib_tick) && !$past(tx_done)));

    // R7
    permit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit && !tx_done) |=> tx_permit);

    // R8
    tx_abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    // R8
    rx_abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |=> !rx_abort);

    // R11
    tx_abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> $past(tx_byte_vld));

    // R11
    rx_abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |-> $past(rx_byte_vld));

    // R10
    huge_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abort || rx_abort) |-> !$past(huge_en));
endmodule

bind tx_gap_guard gap_guard_chk #(.GAP_W(GAP_W), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/tx_gap_guard_tb.sv
module tx_gap_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nib_tick = 1'b0;
    logic        tx_done = 1'b0;
    logic        full_duplex = 1'b1;
    logic [6:0]  gap_set = 7'h12;
    logic        huge_en = 1'b0;
    logic [15:0] max_len = 16'd0;
    logic        tx_byte_vld = 1'b0;
    logic        tx_sof = 1'b0;
    logic        rx_byte_vld = 1'b0;
    logic        rx_sof = 1'b0;
    logic        tx_permit, tx_abort, rx_abort;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    int obs_pulses, obs_idx, obs_other;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_gap_guard dut_i (
        .clk(clk), .rst_n(rst_n), .nib_tick(nib_tick), .tx_done(tx_done),
        .full_duplex(full_duplex), .gap_set(gap_set), .huge_en(huge_en),
        .max_len(max_len), .tx_byte_vld(tx_byte_vld), .tx_sof(tx_sof),
        .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof), .tx_permit(tx_permit),
        .tx_abort(tx_abort), .rx_abort(rx_abort)
    );

    function automatic int exp_gap(bit fd, logic [6:0] gs);
        return int'(gs) + (fd ? 3 : 6);
    endfunction

    function automatic int exp_abort_idx(int len, int maxl, bit huge);
        return (!huge && len > maxl) ? maxl + 1 : 0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_gap(bit fd, logic [6:0] gs, bit perturb, bit tick_on_start, string req);
        int n;
        int guard;
        int exp;
        exp = exp_gap(fd, gs);
        @(negedge clk);
        full_duplex = fd;
        gap_set = gs;
        tx_done = 1'b1;
        nib_tick = tick_on_start;
        @(negedge clk);
        tx_done = 1'b0;
        nib_tick = 1'b0;
        check(tx_permit == 1'b0, "R2", int'(tx_permit), 0);
        n = 0;
        guard = 0;
        while (tx_permit == 1'b0 && guard < 5000) begin
            nib_tick = ($urandom_range(0, 2) != 0);
            if (nib_tick) n++;
            if (perturb) begin
                full_duplex = 1'($urandom);
                gap_set = 7'($urandom);
            end
            @(negedge clk);
            guard++;
        end
        nib_tick = 1'b0;
        check(n == exp, req, n, exp);
        // permit must stay up while ticks keep arriving
        for (int k = 0; k < 4; k++) begin
            nib_tick = 1'b1;
            @(negedge clk);
            check(tx_permit == 1'b1, "R7", int'(tx_permit), 1);
        end
        nib_tick = 1'b0;
    endtask

    task automatic observe(bit path, int last);
        logic a, o;
        a = path ? rx_abort : tx_abort;
        o = path ? tx_abort : rx_abort;
        if (a) begin
            obs_pulses++;
            obs_idx = last;
        end
        if (o) obs_other++;
    endtask

    task automatic drive_byte(bit path, bit vld, bit sof);
        if (path) begin
            rx_byte_vld = vld;
            rx_sof = sof;
        end else begin
            tx_byte_vld = vld;
            tx_sof = sof;
        end
    endtask

    task automatic run_frame(bit path, int len, int maxl, bit huge, string req);
        int last;
        int e_idx;
        e_idx = exp_abort_idx(len, maxl, huge);
        obs_pulses = 0;
        obs_idx = 0;
        obs_other = 0;
        last = 0;
        @(negedge clk);
        max_len = 16'(maxl);
        huge_en = huge;
        for (int i = 1; i <= len; i++) begin
            if (i > 1 && $urandom_range(0, 3) == 0) begin
                @(negedge clk);
                observe(path, last);
                drive_byte(path, 1'b0, 1'b0);
                last = 0;
            end
            @(negedge clk);
            observe(path, last);
            drive_byte(path, 1'b1, i == 1);
            last = i;
        end
        @(negedge clk);
        observe(path, last);
        drive_byte(path, 1'b0, 1'b0);
        last = 0;
        @(negedge clk);
        observe(path, last);
        check(obs_idx == e_idx, req, obs_idx, e_idx);
        check(obs_pulses == (e_idx != 0 ? 1 : 0), "R9", obs_pulses, (e_idx != 0 ? 1 : 0));
        check(obs_other == 0, "R11", obs_other, 0);
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !finished) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_permit == 1'b1, "R1", int'(tx_permit), 1);
        check(tx_abort == 1'b0, "R1", int'(tx_abort), 0);
        check(rx_abort == 1'b0, "R1", int'(rx_abort), 0);

        // R12 bytes before any frame start are ignored
        obs_pulses = 0; obs_idx = 0; obs_other = 0;
        max_len = 16'd0;
        huge_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tx_byte_vld = 1'b1;
            rx_byte_vld = 1'b1;
            @(negedge clk);
            observe(1'b0, 0);
            observe(1'b1, 0);
        end
        tx_byte_vld = 1'b0;
        rx_byte_vld = 1'b0;
        check(obs_pulses == 0 && obs_other == 0, "R12", obs_pulses + obs_other, 0);

        // directed gaps: standard minimum in both modes, extremes
        run_gap(1'b1, 7'h15, 1'b0, 1'b0, "R3");
        run_gap(1'b0, 7'h12, 1'b0, 1'b0, "R4");
        run_gap(1'b1, 7'h00, 1'b0, 1'b0, "R3");
        run_gap(1'b0, 7'h00, 1'b0, 1'b0, "R4");
        run_gap(1'b1, 7'h7F, 1'b0, 1'b0, "R3");
        run_gap(1'b0, 7'h7F, 1'b0, 1'b0, "R4");
        // tick coincident with the start is not counted
        run_gap(1'b1, 7'h05, 1'b0, 1'b1, "R5");
        run_gap(1'b0, 7'h05, 1'b0, 1'b1, "R5");
        // settings changing mid-gap
        run_gap(1'b1, 7'h20, 1'b1, 1'b0, "R6");
        run_gap(1'b0, 7'h20, 1'b1, 1'b0, "R6");

        // restart while running: partial gap, then a fresh full one
        @(negedge clk);
        full_duplex = 1'b1; gap_set = 7'h10; tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        for (int k = 0; k < 7; k++) begin
            nib_tick = 1'b1;
            @(negedge clk);
        end
        nib_tick = 1'b0;
        check(tx_permit == 1'b0, "R2", int'(tx_permit), 0);
        run_gap(1'b0, 7'h09, 1'b0, 1'b0, "R2");

        // random gaps
        for (int r = 0; r < 10; r++) begin
            bit fd;
            logic [6:0] gs;
            fd = 1'($urandom);
            gs = 7'($urandom);
            run_gap(fd, gs, 1'($urandom), 1'($urandom), fd ? "R3" : "R4");
        end

        // directed frames on both paths
        run_frame(1'b0, 10, 10, 1'b0, "R8");
        run_frame(1'b0, 11, 10, 1'b0, "R8");
        run_frame(1'b0, 11, 10, 1'b1, "R10");
        run_frame(1'b0, 18, 10, 1'b0, "R9");
        run_frame(1'b1, 10, 10, 1'b0, "R8");
        run_frame(1'b1, 11, 10, 1'b0, "R8");
        run_frame(1'b1, 30, 10, 1'b1, "R10");
        run_frame(1'b1, 3, 0, 1'b0, "R8");
        run_frame(1'b0, 1, 0, 1'b0, "R8");

        // random frames
        for (int r = 0; r < 20; r++) begin
            int maxl, len;
            bit huge, path;
            maxl = $urandom_range(1, 40);
            len = $urandom_range(1, 50);
            huge = ($urandom_range(0, 3) == 0);
            path = 1'($urandom);
            run_frame(path, len, maxl, huge, huge ? "R10" : "R8");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule